// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block sits beside one processor's cache and gives that processor an atomic read-modify-write built from two ordinary memory operations. A load-reserved request arms a reservation on the cache line that holds the requested byte address. A later store-conditional asks whether that reservation is still intact. Meanwhile the block watches the shared bus for stores issued by other agents. Any such store that lands in the reserved line breaks the reservation. The bus is never locked, and any number of processors may hold reservations on the same line at the same time.

The response to a store-conditional is registered. It appears one cycle after the request as a one-cycle status pulse with a pass or fail flag. When the conditional passes, a one-cycle store-grant pulse lets the store go out on the bus as an ordinary write. Because other processors' copies of this block see that write, their reservations on the line are cancelled. Every store-conditional consumes the local reservation, whether it passes or fails.

The controller has two states. RSV_EMPTY means no reservation is held. RSV_ARMED means a reservation is held on one line. The transitions are:
- ARM: a load-reserved request in RSV_EMPTY moves to RSV_ARMED.
- REARM: a load-reserved request in RSV_ARMED stays in RSV_ARMED with the new line.
- CONSUME: a store-conditional request in RSV_ARMED moves to RSV_EMPTY.
- KILL: a snooped store to the reserved line in RSV_ARMED moves to RSV_EMPTY.
- HOLD: any other cycle leaves the state unchanged.

Top module: `lrsc_unit`

## Requirements
- R1: After reset, and after any later reset, no reservation is held, and `store_grant`, `sc_done` and `sc_pass` are 0.
- R2: A request with `req_valid`=1 and `req_op`=0 (load-reserved) arms a reservation on the line of `req_addr`. Lines are 64 bytes, so the line is `req_addr[31:6]`. This request produces no status pulse.
- R3: A store-conditional (`req_valid`=1, `req_op`=1) passes if a reservation is held and the request's line equals the reserved line. On the next cycle `sc_done`=1, `sc_pass`=1 and `store_grant`=1.
- R4: A store-conditional fails if no reservation is held, or if its line differs from the reserved line. On the next cycle `sc_done`=1, `sc_pass`=0 and `store_grant`=0.
- R5: A snooped store (`snoop_valid`=1) to any byte of the reserved line clears the reservation. A snooped store to any other line leaves it intact.
- R6: Every store-conditional clears the reservation, whether it passes or fails.
- R7: If a store-conditional and a snooped store to the reserved line occur in the same cycle, the store-conditional fails. A snoop to a different line in that cycle has no effect on the result.
- R8: A load-reserved request while a reservation is held replaces the reserved line with the new one.
- R9: If a load-reserved request and a snooped store to the same line occur in the same cycle, the load-reserved request wins and the reservation is armed.
- R10: `store_grant` and `sc_done` are single-cycle pulses, one per store-conditional request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_op | input | 1 | 0 = load-reserved, 1 = store-conditional |
| req_addr | input | 32 | Byte address of the request |
| snoop_valid | input | 1 | A store by another agent is seen on the bus |
| snoop_addr | input | 32 | Byte address of the snooped store |
| store_grant | output | 1 | Pulse: the store-conditional's store may go to the bus |
| sc_done | output | 1 | Pulse: store-conditional result is valid |
| sc_pass | output | 1 | Store-conditional result: 1 = passed, 0 = failed |

## Verification
Two functions can fall in the same cycle: the local request path and the snoop path. The first case pairs a store-conditional with a snooped store. The bench drives both in one cycle, once with the snoop inside the reserved line and once with it in another line. It judges the result from `sc_pass` and `store_grant` one cycle later: a fail with no grant when the lines match, and a pass with a grant otherwise. The second case pairs a load-reserved request with a snoop to the same line. The bench checks that the load-reserved wins by issuing a store-conditional to that line next and expecting it to pass.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    // Reservation controller states
    typedef enum logic [0:0] {
        RSV_EMPTY = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_state_e;

    // Request opcode encoding on req_op
    localparam logic OP_LOAD_RSV  = 1'b0;
    localparam logic OP_STORE_CND = 1'b1;

endpackage

// File: rtl/lrsc_line_match.sv
module lrsc_line_match #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic [LINE_W-1:0] line_ref,
    input  logic [ADDR_W-1:0] addr,
    output logic              same_line
);
    // Byte offset bits inside a line are ignored
    always_comb begin
        same_line = (addr[ADDR_W-1:OFF_W] == line_ref);
    end
endmodule

// File: rtl/lrsc_fsm.sv
module lrsc_fsm
    import lrsc_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_fire,
    input  logic              sc_fire,
    input  logic              snoop_hit,
    input  logic [LINE_W-1:0] req_line,
    output logic              armed,
    output logic [LINE_W-1:0] resv_line
);
    rsv_state_e state_q, state_d;
    logic [LINE_W-1:0] line_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (lr_fire) state_d = RSV_ARMED;                   // ARM
            end
            RSV_ARMED: begin
                if (lr_fire)        state_d = RSV_ARMED;            // REARM
                else if (sc_fire)   state_d = RSV_EMPTY;            // CONSUME
                else if (snoop_hit) state_d = RSV_EMPTY;            // KILL
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (lr_fire) line_q <= req_line;
        end
    end

    // outputs
    always_comb begin
        armed     = (state_q == RSV_ARMED);
        resv_line = line_q;
    end

    // R2 / R9: a load-reserved always leaves the unit armed
    a_r2_lr_arms: assert property (@(posedge clk) disable iff (!rst_n)
        lr_fire |=> armed);
    // R8: the reserved line follows the latest load-reserved
    a_r8_line_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        lr_fire |=> (resv_line == $past(req_line)));
    // R6: any store-conditional leaves nothing reserved
    a_r6_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !lr_fire) |=> !armed);
    // R5: snoop into the reserved line kills the reservation
    a_r5_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !lr_fire) |=> !armed);
endmodule

// File: rtl/lrsc_resp.sv
module lrsc_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_fire,
    input  logic sc_ok,
    output logic store_grant,
    output logic sc_done,
    output logic sc_pass
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_grant <= 1'b0;
            sc_done     <= 1'b0;
            sc_pass     <= 1'b0;
        end else begin
            store_grant <= sc_fire && sc_ok;
            sc_done     <= sc_fire;
            sc_pass     <= sc_fire && sc_ok;
        end
    end

    // R3: a grant only accompanies a passing result
    a_r3_grant_with_pass: assert property (@(posedge clk) disable iff (!rst_n)
        store_grant |-> (sc_done && sc_pass));
    // R10: two grants never follow back to back
    a_r10_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        store_grant |=> !store_grant);
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              store_grant,
    output logic              sc_done,
    output logic              sc_pass
);
    logic              lr_fire, sc_fire;
    logic              armed, req_same, snoop_same, snoop_hit, sc_ok;
    logic [LINE_W-1:0] resv_line;
    logic [LINE_W-1:0] req_line;

    always_comb begin
        lr_fire  = req_valid && (req_op == OP_LOAD_RSV);
        sc_fire  = req_valid && (req_op == OP_STORE_CND);
        req_line = req_addr[ADDR_W-1:OFF_W];
    end

    lrsc_line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_req_cmp (
        .line_ref (resv_line),
        .addr     (req_addr),
        .same_line(req_same)
    );

    lrsc_line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_snoop_cmp (
        .line_ref (resv_line),
        .addr     (snoop_addr),
        .same_line(snoop_same)
    );

    // snoop has priority over a same-cycle store-conditional (R7)
    always_comb begin
        snoop_hit = armed && snoop_valid && snoop_same;
        sc_ok     = armed && req_same && !snoop_hit;
    end

    lrsc_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lr_fire  (lr_fire),
        .sc_fire  (sc_fire),
        .snoop_hit(snoop_hit),
        .req_line (req_line),
        .armed    (armed),
        .resv_line(resv_line)
    );

    lrsc_resp u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sc_fire    (sc_fire),
        .sc_ok      (sc_ok),
        .store_grant(store_grant),
        .sc_done    (sc_done),
        .sc_pass    (sc_pass)
    );

    // R4: with nothing reserved a store-conditional must fail
    a_r4_fail_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !armed) |=> (sc_done && !sc_pass && !store_grant));
    // R7: collision with a snoop into the reserved line fails the request
    a_r7_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && snoop_valid && armed && snoop_same) |=> !store_grant);
    // R10: a result appears only after a store-conditional request
    a_r10_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> $past(sc_fire));
endmodule

// File: tb/lrsc_unit_test.sv
`timescale 1ns/1ps
module lrsc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [31:0] req_addr = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        store_grant, sc_done, sc_pass;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    lrsc_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .store_grant(store_grant), .sc_done(sc_done), .sc_pass(sc_pass)
    );

    typedef struct packed {
        logic        rv;
        logic        op;
        logic [31:0] ra;
        logic        sv;
        logic [31:0] sa;
        logic        eg;
        logic        ed;
        logic        ep;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,32'h0,    1'b0,32'h0,    1'b0,1'b0,1'b0,8'd1},  // R1 idle
        '{1'b1,1'b1,32'h100,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd4},  // R4 SC, none held
        '{1'b1,1'b0,32'h100,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},  // R2 LR no pulse
        '{1'b1,1'b1,32'h13C,  1'b0,32'h0,    1'b1,1'b1,1'b1,8'd3},  // R3 same line passes
        '{1'b1,1'b1,32'h100,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd6},  // R6 consumed
        '{1'b1,1'b0,32'h200,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b0,1'b0,32'h0,    1'b1,32'h240,  1'b0,1'b0,1'b0,8'd5},  // R5 other line
        '{1'b1,1'b1,32'h204,  1'b0,32'h0,    1'b1,1'b1,1'b1,8'd5},  // R5 survived
        '{1'b1,1'b0,32'h300,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b0,1'b0,32'h0,    1'b1,32'h33F,  1'b0,1'b0,1'b0,8'd5},  // R5 last byte
        '{1'b1,1'b1,32'h300,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd5},  // R5 killed
        '{1'b1,1'b0,32'h400,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b1,1'b1,32'h440,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd4},  // R4 line mismatch
        '{1'b1,1'b1,32'h400,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd6},  // R6 failed SC consumed
        '{1'b1,1'b0,32'h500,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b1,1'b0,32'h600,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd8},  // R8 replace
        '{1'b1,1'b1,32'h500,  1'b0,32'h0,    1'b0,1'b1,1'b0,8'd8},  // R8 old line gone
        '{1'b1,1'b0,32'h700,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b1,1'b1,32'h700,  1'b1,32'h710,  1'b0,1'b1,1'b0,8'd7},  // R7 snoop wins
        '{1'b1,1'b0,32'h800,  1'b1,32'h800,  1'b0,1'b0,1'b0,8'd9},  // R9 LR + snoop
        '{1'b1,1'b1,32'h800,  1'b0,32'h0,    1'b1,1'b1,1'b1,8'd9},  // R9 LR won
        '{1'b1,1'b0,32'h900,  1'b0,32'h0,    1'b0,1'b0,1'b0,8'd2},
        '{1'b1,1'b1,32'h900,  1'b1,32'hA00,  1'b1,1'b1,1'b1,8'd7},  // R7 other-line snoop
        '{1'b0,1'b0,32'h0,    1'b0,32'h0,    1'b0,1'b0,1'b0,8'd10}  // R10 pulses end
    };

    task automatic check(input int rq, input logic g, input logic d, input logic p,
                         input logic eg, input logic ed, input logic ep);
        checks++;
        if ({g, d, p} !== {eg, ed, ep}) begin
            errors++;
            $display("FAIL R%0d: grant/done/pass=%b%b%b expected %b%b%b",
                     rq, g, d, p, eg, ed, ep);
        end
    endtask

    // drive one cycle of inputs, then sample the registered outputs after the edge
    task automatic step(input logic rv, input logic op, input logic [31:0] ra,
                        input logic sv, input logic [31:0] sa);
        req_valid = rv; req_op = op; req_addr = ra;
        snoop_valid = sv; snoop_addr = sa;
        @(posedge clk); #1;
        req_valid = 1'b0; snoop_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        // R1: outputs low while in reset
        check(1, store_grant, sc_done, sc_pass, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check(1, store_grant, sc_done, sc_pass, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].rv, VEC[i].op, VEC[i].ra, VEC[i].sv, VEC[i].sa);
            check(int'(VEC[i].req), store_grant, sc_done, sc_pass,
                  VEC[i].eg, VEC[i].ed, VEC[i].ep);
        end

        // R1: reset drops a held reservation
        step(1'b1, 1'b0, 32'hB00, 1'b0, 32'h0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(1, store_grant, sc_done, sc_pass, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        step(1'b1, 1'b1, 32'hB00, 1'b0, 32'h0);
        check(1, store_grant, sc_done, sc_pass, 1'b0, 1'b1, 1'b0);

        // R3 / R10: back-to-back LR, SC, then one idle cycle drops the pulse
        step(1'b1, 1'b0, 32'hC3F, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'hC00, 1'b1, 32'hC40);
        check(3, store_grant, sc_done, sc_pass, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
        check(10, store_grant, sc_done, sc_pass, 1'b0, 1'b0, 1'b0);

        // R5: snoop while nothing held leaves nothing to pass
        step(1'b0, 1'b0, 32'h0, 1'b1, 32'hD00);
        step(1'b1, 1'b1, 32'hD00, 1'b0, 32'h0);
        check(5, store_grant, sc_done, sc_pass, 1'b0, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule